// File: doc/BRIEF.md
# Set/Clear-Masked Interrupt Controller

This block collects one-cycle event pulses from five peripheral sources and raises an active-high interrupt line when an enabled source fires. The sources are timer A, timer B, the time-of-day alarm, the serial port and an external flag pin. Each source has a sticky flag that latches its event whatever the enable state. An enable mask decides which sources may raise the interrupt.

A single register location serves two purposes. A write changes the mask. Bit 7 of the written byte picks the mode: when it is 1, the addressed mask bits are set, and when it is 0, they are cleared. The addressed bits are those with a 1 in data bits 4:0. A read returns the latched flags together with a summary bit in bit 7 that shows an interrupt is pending. The same read then wipes the flags and the summary bit.

Reads are qualified by a synchronous strobe. The returned byte is valid during the strobe cycle, and the clear takes effect at the end of that cycle.

Top module: `sc_irq_ctrl`

## Requirements
- R1: Reset clears the mask, all flags, the summary bit and `irq`, so a read after reset returns 0x00.
- R2: An event pulse on `src_evt[i]` sets flag bit i of the read data from the next cycle on, whatever the mask. The bit assignment is 0 timer A, 1 timer B, 2 alarm, 3 serial port and 4 flag pin.
- R3: A write with `wdata[7]`=1 sets every mask bit whose `wdata[4:0]` bit is 1 and leaves the other mask bits as they were.
- R4: A write with `wdata[7]`=0 clears every mask bit whose `wdata[4:0]` bit is 1 and leaves the other mask bits as they were.
- R5: Written bits 6:5 have no effect on the mask, in either mode.
- R6: An event on a source whose mask bit is set makes read-data bit 7 and `irq` go to 1 in the next cycle.
- R7: An event on a source whose mask bit is clear latches the flag but leaves bit 7 and `irq` at 0.
- R8: A read returns {pending, 2'b00, flags[4:0]}. From the next cycle, all flags, bit 7 and `irq` are 0.
- R9: An event that arrives in the same cycle as a read is not returned by that read. It is kept for the next read, and it sets bit 7 if its mask bit is set.
- R10: Setting a mask bit whose flag is already latched sets bit 7 and `irq` in the next cycle.
- R11: Clearing a mask bit does not withdraw a pending interrupt; only a read or reset clears bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | NSRC | One-cycle event pulses, one per source |
| wr_en | input | 1 | Write strobe for the mask update |
| wdata | input | DW | Write data: bit 7 selects set or clear, bits 4:0 select the sources |
| rd_en | input | 1 | Read strobe; clears the flags and the summary bit at the end of the cycle |
| rdata | output | DW | Summary bit, zero fill, flags |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its defaults, NSRC=5 and DW=8. With these values every one of the five source positions and both zero-fill bits 6:5 can be seen in the read byte. The 8-bit width also places the mode bit at bit 7, so both set and clear writes can be exercised with stray bits in 6:5. Coincident read-and-event cycles, late mask enables and mask clears on pending interrupts are all reachable at this size.

// File: rtl/sc_irq_ctrl.sv
module sc_irq_ctrl #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic            rd_en,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam int MODE_BIT = DW - 1;
  localparam int PAD      = DW - 1 - NSRC;

  logic [NSRC-1:0] mask_q, mask_d, flag_q, flag_d, flag_kept, sel;
  logic            pend_q, pend_d, pend_kept, set_mode;

  assign sel       = wdata[NSRC-1:0];
  assign set_mode  = wdata[MODE_BIT];
  assign mask_d    = !wr_en ? mask_q : (set_mode ? (mask_q | sel) : (mask_q & ~sel));
  assign flag_kept = rd_en ? '0 : flag_q;
  assign pend_kept = rd_en ? 1'b0 : pend_q;
  assign flag_d    = flag_kept | src_evt;
  assign pend_d    = pend_kept
                   | (|(src_evt & mask_d))
                   | (wr_en & set_mode & (|(sel & flag_kept)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
      pend_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assign rdata = {pend_q, {PAD{1'b0}}, flag_q};
  assign irq   = pend_q;
endmodule

// File: rtl/sc_irq_ctrl_chk.sv
module sc_irq_ctrl_chk #(
  parameter int NSRC = 5,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_evt,
  input logic            wr_en,
  input logic [DW-1:0]   wdata,
  input logic            rd_en,
  input logic [DW-1:0]   rdata,
  input logic            irq,
  input logic [NSRC-1:0] mask_q
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (rdata == '0 && !irq));

  p_flag_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((rdata[NSRC-1:0] & $past(src_evt)) == $past(src_evt)));

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[DW-1]) |=> ((mask_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[DW-1]) |=> ((mask_q & $past(wdata[NSRC-1:0])) == '0));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !wr_en && ((src_evt & mask_q) == '0)) |=> !irq);

  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && src_evt == '0) |=> (rdata == '0 && !irq));

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_en) |=> irq);
endmodule

bind sc_irq_ctrl sc_irq_ctrl_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .irq(irq), .mask_q(mask_q)
);

// File: tb/sc_irq_ctrl_test.sv
`timescale 1ns/1ps
module sc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] src_evt = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  sc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq)
  );

  task automatic step(input logic [4:0] e, input logic w, input logic [7:0] wd,
                      input logic r, input logic [7:0] exp_rd, input string tag);
    @(posedge clk); #2;
    src_evt = e; wr_en = w; wdata = wd; rd_en = r;
    if (r) begin
      exp_q.push_back(exp_rd);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle();
    step(5'h00, 1'b0, 8'h00, 1'b0, 8'h00, "");
  endtask

  task automatic evt(input logic [4:0] e);
    step(e, 1'b0, 8'h00, 1'b0, 8'h00, "");
  endtask

  task automatic wr(input logic [7:0] d);
    step(5'h00, 1'b1, d, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic [7:0] exp_rd, input string tag);
    step(5'h00, 1'b0, 8'h00, 1'b1, exp_rd, tag);
  endtask

  task automatic chk_irq(input logic exp_irq, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== exp_irq) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp_irq);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      logic [7:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read rdata actual=%02h expected=none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s rdata actual=%02h expected=%02h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk_irq(1'b0, "R1 after reset");
    rd(8'h00, "R1 read after reset");

    evt(5'h01); rd(8'h01, "R2 R7 timer A unmasked");
    chk_irq(1'b0, "R7 no irq when unmasked");
    idle();

    wr(8'h81);
    evt(5'h01); idle();
    chk_irq(1'b1, "R6 masked timer A raises irq");
    rd(8'h81, "R6 pending bit in read");
    chk_irq(1'b1, "R8 irq during read cycle");
    idle();
    chk_irq(1'b0, "R8 irq cleared by read");
    rd(8'h00, "R8 flags cleared by read");

    evt(5'h16); rd(8'h16, "R2 R7 bits 1 2 4 unmasked");

    wr(8'h9C); wr(8'h01);
    evt(5'h01); rd(8'h01, "R4 cleared bit 0 no pending");
    evt(5'h10); rd(8'h90, "R3 set bit 4 pending");
    evt(5'h02); rd(8'h02, "R3 bit 1 untouched by set");
    evt(5'h08); rd(8'h88, "R4 bit 3 untouched by clear");

    wr(8'hE0); wr(8'h60);
    evt(5'h04); rd(8'h84, "R5 stray bits kept mask bit 2");
    evt(5'h03); rd(8'h03, "R5 stray bits set nothing");

    evt(5'h01);
    step(5'h08, 1'b0, 8'h00, 1'b1, 8'h01, "R9 coincident event not returned");
    rd(8'h88, "R9 coincident event kept");
    rd(8'h00, "R9 second read empty");

    evt(5'h02); idle();
    chk_irq(1'b0, "R10 latched flag without mask");
    wr(8'h82); idle();
    chk_irq(1'b1, "R10 late mask enable");
    rd(8'h82, "R10 pending after late enable");

    evt(5'h04); wr(8'h04); idle();
    chk_irq(1'b1, "R11 mask clear keeps pending");
    rd(8'h84, "R11 read after mask clear");

    evt(5'h1F); idle();
    chk_irq(1'b1, "R1 pending before reset");
    @(posedge clk); #2 rst_n = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    chk_irq(1'b0, "R1 irq after mid-run reset");
    rd(8'h00, "R1 flags after mid-run reset");
    evt(5'h1F); rd(8'h1F, "R1 mask cleared by reset");
    idle(); idle();

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R8 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule